// File: doc/BRIEF.md
# Serial DAC Register Interface

This block is the digital front end of a single-channel 12-bit output converter. A host sends 24-bit words over a three-wire serial link made of a bit clock, a data line and a framing strobe. The top byte of each word names a target and the low 16 bits carry its payload. On each rising edge of the strobe, the block decodes the word it has collected. The word can load the 12-bit output code, load the control fields, clear the register set or arm a readback.

The three serial inputs are asynchronous to the system clock. They pass through flop synchronizers, and their edges are found in the system clock domain. The code and the control fields are exported as plain ports to the analog and slew logic. Three status conditions come in as plain signals and can be read back. The serial output has a separate drive-enable so that the pad can be tri-stated. It returns a register during the transaction that follows a readback setup. When chaining is enabled, it passes on the bits that fall off the end of the shift register, which lets several converters share one link.

Top module: `dac_serial_port`

## Requirements
- R1: Words are shifted in MSB first, one bit per rising edge of `sclk_in`, whatever the level of `latch_in`. On a rising edge of `latch_in`, the last 24 bits shifted in form the word that is decoded: bits 23:16 are the target byte and bits 15:0 are the payload.
- R2: With chaining off, a strobe edge that follows other than exactly 24 clock rises (counted since the previous strobe edge or reset) changes no register and leaves `sdo_drive` low.
- R3: Target 0x01 loads `dac_code` from payload bits 15:4. Payload bits 3:0 have no effect, and `dac_code` changes only on such a word or on a clear.
- R4: Target 0x55 loads the control fields from these payload bits: 13 `ext_rset_sel`, 12 `out_en`, 11:8 `slew_clk_sel`, 7:5 `slew_step`, 4 `slew_en`, 3 `daisy_en`, 2:0 `range_sel`. Bits 15:14 are stored as zero.
- R5: Target 0x00 (no operation) and any target not listed here leave every register unchanged.
- R6: Target 0x02 arms a readback, and payload bits 1:0 choose the value: 00 status, 01 data, 10 control, 11 zero. The status value has fault in bit 0, slewing in bit 1, over-temperature in bit 2 and zero elsewhere, and is sampled when the setup word is latched. The data value has the code in bits 15:4 and zeros below. The control value is returned as stored. In the next transaction, `sdo` gives 8 zero bits and then the 16-bit value MSB first. It updates after each falling edge of `sclk_in`, so bit k is valid at rise k.
- R7: `sdo_drive` is low after reset. It goes high on the strobe edge that completes a readback setup and goes low on the next strobe edge. `sdo` is high-impedance whenever `sdo_drive` is low.
- R8: With control bit 3 set, `sdo_drive` stays high. After each falling edge of `sclk_in`, `sdo` gives the bit shifted in 24 rises earlier. The 24-count rule is waived, so the last 24 bits of a longer burst are decoded.
- R9: Target 0x56 with payload bit 0 set returns the code and all control fields to zero. With bit 0 clear, it has no effect.
- R10: Synchronous reset clears the code, the control fields, the bit count and the readback state.
- R11: The inputs pass through `SYNC_STAGES` flops. The exported registers show the effect of a word no more than four clock cycles after `latch_in` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial bit clock, asynchronous |
| sdin_in | input | 1 | Serial data in, sampled on bit-clock rise |
| latch_in | input | 1 | Framing strobe, acts on its rising edge |
| fault_in | input | 1 | Output fault condition (status bit 0) |
| slewing_in | input | 1 | Slew in progress (status bit 1) |
| overtemp_in | input | 1 | Over-temperature condition (status bit 2) |
| sdo | output | 1 | Serial data out, high-impedance when not driven |
| sdo_drive | output | 1 | High while `sdo` is driven |
| dac_code | output | 12 | Output code for the converter |
| range_sel | output | 3 | Output range selection |
| daisy_en | output | 1 | Chaining mode enabled |
| slew_en | output | 1 | Slew engine enabled |
| slew_step | output | 3 | Slew step size selection |
| slew_clk_sel | output | 4 | Slew update rate selection |
| out_en | output | 1 | Output stage enabled |
| ext_rset_sel | output | 1 | External current-setting resistor selected |

## Verification
A behavioural model, kept up to date by the stimulus tasks, is compared with the code, control and drive outputs on every clock. The bench sends well-formed words to each target, including payloads with reserved and ignored bits set. These show which payload bits are used and which are dropped. Bursts of 23 and 25 clocks test the frame-count rule. A strobe edge that follows a 25-clock burst whose last 24 bits look like a readback setup shows that a discarded word cannot arm the output. Readbacks of each selector, taken with different status patterns, check the bit order and the enable window. A 48-clock chained burst is checked bit by bit against the word shifted in 24 rises earlier, which separates the pass-through path from the readback path.

// File: rtl/dacsp_pkg.sv
package dacsp_pkg;

    localparam int WORD_W    = 24;
    localparam int ADDR_W    = 8;
    localparam int PAYLOAD_W = WORD_W - ADDR_W;
    localparam int CODE_W    = 12;
    localparam int CODE_LSB  = PAYLOAD_W - CODE_W;
    localparam int PAD_W     = WORD_W - PAYLOAD_W;
    localparam int CNT_W     = $clog2(WORD_W + 2);

    typedef enum logic [ADDR_W-1:0] {
        CMD_NOP   = 8'h00,
        CMD_DATA  = 8'h01,
        CMD_READ  = 8'h02,
        CMD_CTRL  = 8'h55,
        CMD_RESET = 8'h56
    } cmd_e;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'b00,
        SEL_DATA   = 2'b01,
        SEL_CTRL   = 2'b10,
        SEL_NONE   = 2'b11
    } rdsel_e;

    typedef struct packed {
        logic [ADDR_W-1:0]    addr;
        logic [PAYLOAD_W-1:0] payload;
    } word_t;

    typedef struct packed {
        logic [1:0] rsvd;
        logic       ext_rset;
        logic       out_en;
        logic [3:0] slew_clk;
        logic [2:0] slew_step;
        logic       slew_en;
        logic       daisy;
        logic [2:0] range;
    } ctl_t;

    function automatic ctl_t ctl_from_payload(input logic [PAYLOAD_W-1:0] p);
        ctl_t c;
        c = ctl_t'(p);
        c.rsvd = '0;
        return c;
    endfunction

    function automatic logic [PAYLOAD_W-1:0] status_word(input logic flt,
                                                         input logic slw,
                                                         input logic hot);
        return {{(PAYLOAD_W-3){1'b0}}, hot, slw, flt};
    endfunction

endpackage

// File: rtl/dacsp_sync.sv
module dacsp_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);

    generate
        for (genvar g = 0; g < N; g++) begin : g_chain
            logic [STAGES-1:0] stage_q;
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= {stage_q[STAGES-2:0], async_in[g]};
            end
            assign sync_out[g] = stage_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/dacsp_frame.sv
module dacsp_frame
    import dacsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_rise,
    input  logic             sdin,
    input  logic             latch_rise,
    input  logic             daisy_en,
    output word_t            word,
    output logic [CNT_W-1:0] bit_cnt,
    output logic             frame_go,
    output logic             chain_bit
);

    logic [WORD_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else begin
            if (sclk_rise)
                shreg <= {shreg[WORD_W-2:0], sdin};
            if (latch_rise)
                bit_cnt <= sclk_rise ? CNT_W'(1) : '0;
            else if (sclk_rise && bit_cnt != '1)
                bit_cnt <= bit_cnt + CNT_W'(1);
        end
    end

    assign word      = word_t'(shreg);
    assign chain_bit = shreg[WORD_W-1];
    assign frame_go  = latch_rise && (daisy_en || bit_cnt == CNT_W'(WORD_W));

endmodule

// File: rtl/dacsp_regs.sv
module dacsp_regs
    import dacsp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_go,
    input  word_t                word,
    input  logic                 fault,
    input  logic                 slewing,
    input  logic                 overtemp,
    output ctl_t                 ctl,
    output logic [CODE_W-1:0]    code,
    output logic                 rd_load,
    output logic [PAYLOAD_W-1:0] rd_value
);

    rdsel_e sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
            ctl  <= '0;
        end else if (frame_go) begin
            case (word.addr)
                CMD_DATA:  code <= word.payload[PAYLOAD_W-1:CODE_LSB];
                CMD_CTRL:  ctl  <= ctl_from_payload(word.payload);
                CMD_RESET: begin
                    if (word.payload[0]) begin
                        code <= '0;
                        ctl  <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign sel     = rdsel_e'(word.payload[1:0]);
    assign rd_load = frame_go && (word.addr == CMD_READ);

    always_comb begin
        case (sel)
            SEL_STATUS: rd_value = status_word(fault, slewing, overtemp);
            SEL_DATA:   rd_value = {code, {CODE_LSB{1'b0}}};
            SEL_CTRL:   rd_value = ctl;
            default:    rd_value = '0;
        endcase
    end

endmodule

// File: rtl/dacsp_sdo.sv
module dacsp_sdo
    import dacsp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sclk_fall,
    input  logic                 latch_rise,
    input  logic                 rd_load,
    input  logic [PAYLOAD_W-1:0] rd_value,
    input  logic                 daisy_en,
    input  logic                 chain_bit,
    output logic                 sdo_bit,
    output logic                 armed
);

    logic [WORD_W-1:0] oreg;
    logic [WORD_W-1:0] rd_frame;

    assign rd_frame = {{PAD_W{1'b0}}, rd_value};

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            oreg    <= '0;
            sdo_bit <= 1'b0;
        end else if (latch_rise) begin
            armed <= rd_load;
            if (rd_load) begin
                sdo_bit <= rd_frame[WORD_W-1];
                oreg    <= rd_frame << 1;
            end
        end else if (sclk_fall) begin
            if (armed || !daisy_en) begin
                sdo_bit <= oreg[WORD_W-1];
                oreg    <= oreg << 1;
            end else begin
                sdo_bit <= chain_bit;
            end
        end
    end

endmodule

// File: rtl/dac_serial_port.sv
module dac_serial_port
    import dacsp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_in,
    input  logic              sdin_in,
    input  logic              latch_in,
    input  logic              fault_in,
    input  logic              slewing_in,
    input  logic              overtemp_in,
    output logic              sdo,
    output logic              sdo_drive,
    output logic [CODE_W-1:0] dac_code,
    output logic [2:0]        range_sel,
    output logic              daisy_en,
    output logic              slew_en,
    output logic [2:0]        slew_step,
    output logic [3:0]        slew_clk_sel,
    output logic              out_en,
    output logic              ext_rset_sel
);

    localparam int N_IN = 3;

    logic [N_IN-1:0]      raw_in;
    logic [N_IN-1:0]      synced;
    logic                 sclk_d, latch_d;
    logic                 sclk_rise, sclk_fall, latch_rise;
    word_t                word_q;
    logic [CNT_W-1:0]     bit_cnt;
    logic                 frame_go, chain_bit;
    ctl_t                 ctl_q;
    logic                 rd_load;
    logic [PAYLOAD_W-1:0] rd_value;
    logic                 sdo_bit, armed;

    assign raw_in = {latch_in, sdin_in, sclk_in};

    dacsp_sync #(.N(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(raw_in), .sync_out(synced)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= 1'b0;
            latch_d <= 1'b0;
        end else begin
            sclk_d  <= synced[0];
            latch_d <= synced[2];
        end
    end

    assign sclk_rise  =  synced[0] & ~sclk_d;
    assign sclk_fall  = ~synced[0] &  sclk_d;
    assign latch_rise =  synced[2] & ~latch_d;

    dacsp_frame u_frame (
        .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .sdin(synced[1]),
        .latch_rise(latch_rise), .daisy_en(ctl_q.daisy), .word(word_q),
        .bit_cnt(bit_cnt), .frame_go(frame_go), .chain_bit(chain_bit)
    );

    dacsp_regs u_regs (
        .clk(clk), .rst(rst), .frame_go(frame_go), .word(word_q),
        .fault(fault_in), .slewing(slewing_in), .overtemp(overtemp_in),
        .ctl(ctl_q), .code(dac_code), .rd_load(rd_load), .rd_value(rd_value)
    );

    dacsp_sdo u_sdo (
        .clk(clk), .rst(rst), .sclk_fall(sclk_fall), .latch_rise(latch_rise),
        .rd_load(rd_load), .rd_value(rd_value), .daisy_en(ctl_q.daisy),
        .chain_bit(chain_bit), .sdo_bit(sdo_bit), .armed(armed)
    );

    assign sdo_drive    = armed | ctl_q.daisy;
    assign sdo          = sdo_drive ? sdo_bit : 1'bz;
    assign range_sel    = ctl_q.range;
    assign daisy_en     = ctl_q.daisy;
    assign slew_en      = ctl_q.slew_en;
    assign slew_step    = ctl_q.slew_step;
    assign slew_clk_sel = ctl_q.slew_clk;
    assign out_en       = ctl_q.out_en;
    assign ext_rset_sel = ctl_q.ext_rset;

endmodule

// File: rtl/dacsp_checker.sv
module dacsp_checker
    import dacsp_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 frame_go,
    input logic                 latch_rise,
    input logic                 sclk_fall,
    input logic                 daisy_en,
    input logic                 sdo_bit,
    input logic                 sdo_drive,
    input logic [CNT_W-1:0]     bit_cnt,
    input logic [CODE_W-1:0]    dac_code,
    input logic [PAYLOAD_W-1:0] ctl_bits,
    input word_t                word
);

    assert_code_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !frame_go |=> $stable(dac_code));

    assert_code_load_R3: assert property (@(posedge clk) disable iff (rst)
        (frame_go && word.addr == CMD_DATA)
        |=> dac_code == $past(word.payload[PAYLOAD_W-1:CODE_LSB]));

    assert_bad_count_R2: assert property (@(posedge clk) disable iff (rst)
        (latch_rise && !daisy_en && bit_cnt != CNT_W'(WORD_W))
        |=> ($stable(dac_code) && $stable(ctl_bits)));

    assert_sdo_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (!sclk_fall && !latch_rise) |=> $stable(sdo_bit));

    assert_drive_on_latch_R7: assert property (@(posedge clk) disable iff (rst)
        !latch_rise |=> $stable(sdo_drive));

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (frame_go && word.addr == CMD_RESET && word.payload[0])
        |=> (dac_code == '0 && ctl_bits == '0));

endmodule

bind dac_serial_port dacsp_checker u_chk (
    .clk(clk), .rst(rst), .frame_go(frame_go), .latch_rise(latch_rise),
    .sclk_fall(sclk_fall), .daisy_en(daisy_en), .sdo_bit(sdo_bit),
    .sdo_drive(sdo_drive), .bit_cnt(bit_cnt), .dac_code(dac_code),
    .ctl_bits(ctl_q), .word(word_q)
);

// File: tb/dac_serial_port_test.sv
module dac_serial_port_test;

    localparam int HALF = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, sclk, sdin, latch, f_in, s_in, t_in;
    wire  sdo;
    logic sdo_drive, daisy, sen, oe, ext;
    logic [11:0] code;
    logic [2:0]  range, step;
    logic [3:0]  sclk_sel;

    dac_serial_port uut (
        .clk(clk), .rst(rst), .sclk_in(sclk), .sdin_in(sdin), .latch_in(latch),
        .fault_in(f_in), .slewing_in(s_in), .overtemp_in(t_in),
        .sdo(sdo), .sdo_drive(sdo_drive), .dac_code(code), .range_sel(range),
        .daisy_en(daisy), .slew_en(sen), .slew_step(step), .slew_clk_sel(sclk_sel),
        .out_en(oe), .ext_rset_sel(ext)
    );

    int vectors = 0;
    int miscmp  = 0;
    int blackout = 0;
    bit done = 0;

    logic [11:0] m_code;
    logic [15:0] m_ctl;
    bit          m_armed;
    logic [15:0] m_rd;
    int          m_cnt;
    bit          hist[$];

    function automatic void check(bit ok, string req, string what, int act, int exp);
        vectors++;
        if (!ok) begin
            miscmp++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endfunction

    function automatic void model_reset();
        m_code = '0; m_ctl = '0; m_armed = 0; m_rd = '0; m_cnt = 0;
        hist.delete();
        for (int i = 0; i < 24; i++) hist.push_back(1'b0);
    endfunction

    function automatic void model_latch();
        logic [23:0] w;
        bit ok;
        for (int i = 0; i < 24; i++) w[23-i] = hist[hist.size()-24+i];
        ok = m_ctl[3] || (m_cnt == 24);
        m_cnt = 0;
        m_armed = 0;
        if (ok) begin
            case (w[23:16])
                8'h01: m_code = w[15:4];
                8'h55: m_ctl = {2'b00, w[13:0]};
                8'h56: if (w[0]) begin m_code = '0; m_ctl = '0; end
                8'h02: begin
                    m_armed = 1;
                    case (w[1:0])
                        2'b00:   m_rd = {13'b0, t_in, s_in, f_in};
                        2'b01:   m_rd = {m_code, 4'b0000};
                        2'b10:   m_rd = m_ctl;
                        default: m_rd = '0;
                    endcase
                end
                default: ;
            endcase
        end
    endfunction

    function automatic logic [15:0] ctl_out();
        return {2'b00, ext, oe, sclk_sel, step, sen, daisy, range};
    endfunction

    // Per-clock comparison; R11: outputs settle within the blackout window
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (blackout > 0) blackout--;
            else begin
                check(code == m_code, "R3", "dac_code", int'(code), int'(m_code));
                check(ctl_out() == m_ctl, "R4", "control", int'(ctl_out()), int'(m_ctl));
                check(sdo_drive == (m_armed || m_ctl[3]), "R7", "sdo_drive",
                      int'(sdo_drive), int'(m_armed || m_ctl[3]));
            end
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic clock_bit(bit b, int k);
        sdin = b;
        wait_clk(HALF);
        if (m_armed && k >= 9)
            check(sdo == m_rd[24-k], "R6", $sformatf("readback rise %0d", k),
                  int'(sdo), int'(m_rd[24-k]));
        else if (!m_armed && m_ctl[3] && k >= 2)
            check(sdo == hist[hist.size()-24], "R8", $sformatf("chain rise %0d", k),
                  int'(sdo), int'(hist[hist.size()-24]));
        sclk = 1'b1;
        hist.push_back(b);
        if (m_cnt < 31) m_cnt++;
        wait_clk(HALF);
        sclk = 1'b0;
    endtask

    task automatic send_bits(logic [47:0] v, int n);
        for (int i = n - 1; i >= 0; i--) clock_bit(v[i], n - i);
        wait_clk(HALF);
    endtask

    task automatic pulse_latch();
        latch = 1'b1;
        model_latch();
        blackout = 4;
        wait_clk(HALF + 2);
        latch = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic write_word(logic [23:0] w);
        send_bits({24'h0, w}, 24);
        pulse_latch();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            vectors++;
            miscmp++;
            $display("FAIL R1 watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1; sclk = 0; sdin = 0; latch = 0; f_in = 0; s_in = 0; t_in = 0;
        model_reset();
        wait_clk(5);
        rst = 0;
        wait_clk(2);
        // R10: reset state
        check(code == 0 && ctl_out() == 0, "R10", "reset regs", int'({code, ctl_out()}), 0);
        check(sdo_drive == 0, "R10", "reset sdo_drive", int'(sdo_drive), 0);

        // R1 R3: data word, low payload bits ignored
        write_word(24'h01ABCF);
        check(code == 12'hABC, "R3", "data load", int'(code), 'hABC);

        // R4: control fields with reserved bits set
        write_word(24'h55F3A5);
        check(ctl_out() == 16'h33A5, "R4", "control load", int'(ctl_out()), 'h33A5);
        check(ext == 1 && oe == 1, "R4", "ext/oe", int'({ext, oe}), 3);
        check(sclk_sel == 4'h3 && step == 3'd5 && sen == 0, "R4", "slew fields",
              int'({sclk_sel, step, sen}), int'({4'h3, 3'd5, 1'b0}));
        check(range == 3'd5 && daisy == 0, "R4", "range/chain", int'({range, daisy}), 'hA);

        // R2: short and long bursts discarded
        send_bits(48'h011230 >> 1, 23);
        pulse_latch();
        check(code == 12'hABC, "R2", "23-bit burst", int'(code), 'hABC);
        send_bits({23'h0, 24'h010200, 1'b1}, 25);
        pulse_latch();
        check(code == 12'hABC && sdo_drive == 0, "R2", "25-bit burst",
              int'({code, sdo_drive}), int'({12'hABC, 1'b0}));

        // R5: no-op and undefined target
        write_word(24'h000000);
        write_word(24'h7F0123);
        check(code == 12'hABC && ctl_out() == 16'h33A5, "R5", "no effect",
              int'({code, ctl_out()}), int'({12'hABC, 16'h33A5}));

        // R6 R7: data readback
        write_word(24'h020001);
        check(sdo_drive == 1, "R7", "drive after setup", int'(sdo_drive), 1);
        write_word(24'h000000);
        check(sdo_drive == 0, "R7", "drive after readout", int'(sdo_drive), 0);

        // R6: control, status and unused selector
        write_word(24'h020002);
        write_word(24'h000000);
        f_in = 1; s_in = 0; t_in = 1;
        write_word(24'h020000);
        write_word(24'h000000);
        f_in = 0; s_in = 1; t_in = 0;
        write_word(24'h020000);
        write_word(24'h000000);
        write_word(24'h020003);
        write_word(24'h000000);

        // R9: clear register
        write_word(24'h560000);
        check(code == 12'hABC, "R9", "clear bit low", int'(code), 'hABC);
        write_word(24'h560001);
        check(code == 0 && ctl_out() == 0, "R9", "clear bit high",
              int'({code, ctl_out()}), 0);

        // R8 R1: chaining, 48-clock burst
        write_word(24'h550008);
        check(daisy == 1 && sdo_drive == 1, "R8", "chain enable", int'({daisy, sdo_drive}), 3);
        send_bits({24'h015A50, 24'h013C30}, 48);
        pulse_latch();
        check(code == 12'h3C3, "R8", "last word of burst", int'(code), 'h3C3);
        write_word(24'h550000);
        check(sdo_drive == 0, "R8", "chain disable", int'(sdo_drive), 0);

        // R10: reset mid-run
        write_word(24'h01FFF0);
        check(code == 12'hFFF, "R3", "full-scale code", int'(code), 'hFFF);
        rst = 1;
        model_reset();
        wait_clk(3);
        rst = 0;
        wait_clk(2);
        check(code == 0 && ctl_out() == 0 && sdo_drive == 0, "R10", "reset mid-run",
              int'({code, sdo_drive}), 0);
        write_word(24'h010120);
        check(code == 12'h012, "R2", "count restarts after reset", int'(code), 'h012);

        done = 1;
        summary();
        $finish;
    end

endmodule